// File: doc/BRIEF.md
# Tagged block read engine

The engine moves a run of equal-sized data blocks out of one memory bank into a local store that holds two blocks. Each block is broken into single-beat read requests. Every request in a block carries a transaction tag that names the store slot the block will land in, so even blocks use tag 0 and odd blocks use tag 1. A counter for each tag tracks the requests still outstanding. The engine can therefore wait for one block to finish while the requests of the following block are already in the network. This keeps the bank busy instead of leaving it idle between blocks.

Software loads the block count and the number of requests per block, then pulses `start`. The engine hands each finished block to a consumer with a valid/acknowledge pair. While the block is offered, the consumer reads its beats through a small read port. After the last block is acknowledged, the engine raises `done`. A slot and its tag are used again only after the consumer has acknowledged the block that was held there.

Top module: `tagrd_engine`

## Requirements
- R1: Block k is issued and stored with tag and slot k mod 2, so even blocks use 0 and odd blocks use 1. Every request of a block carries that tag, and `blk_slot` reports the same value when the block is offered.
- R2: Request n of a run, counted from 0 across all blocks, has `req_addr` equal to {BANK_SEL in the upper ADDR_W-BANK_AW bits, n mod 2^BANK_AW in the lower BANK_AW bits}. The upper bits never change.
- R3: Block k is offered on `blk_valid` only after every request of block k+1 has been accepted, or after all requests have been accepted when k is the last block. `blk_valid` and `blk_slot` hold steady until `blk_ack`.
- R4: A block is offered only when every response with its tag has returned. Responses with the other tag do not make it ready.
- R5: While a block is offered, `rd_data` at `rd_idx` = i is the i-th response that arrived for that block's tag.
- R6: The first request of block k, for k >= 2, is not presented until block k-2 has been acknowledged.
- R7: While `req_ready` is low, `req_valid` stays high with a stable address and tag. A run accepts exactly blocks × requests-per-block requests.
- R8: A response whose tag has no outstanding request sets a sticky `err`, is not stored and changes no counter. A new `start` clears `err`.
- R9: `done` rises once the last block has been acknowledged. A run of zero blocks reaches `done` on the cycle after `start`, and `done` stops further requests.
- R10: During and after reset, `req_valid`, `blk_valid`, `busy`, `done` and `err` are low.
- R11: A `start` pulse while a run is busy is ignored, and so is any change to the configuration during that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run with the current configuration |
| cfg_nblk | input | BLK_W | Number of blocks in the run |
| cfg_reqs | input | REQ_W | Requests per block, from 1 to MAX_REQS |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last block acknowledged |
| err | output | 1 | Sticky stray-response flag |
| req_valid | output | 1 | Read request presented |
| req_ready | input | 1 | Request accepted when high with req_valid |
| req_addr | output | ADDR_W | Request address inside the bank |
| req_tag | output | 1 | Request transaction tag |
| rsp_valid | input | 1 | Response beat present |
| rsp_tag | input | 1 | Response transaction tag |
| rsp_data | input | DATA_W | Response beat |
| blk_valid | output | 1 | A complete block is offered |
| blk_slot | output | 1 | Slot and tag of the offered block |
| blk_ack | input | 1 | Consumer is done with the offered block |
| rd_idx | input | IDX_W | Beat index read from the offered block |
| rd_data | output | DATA_W | Beat at rd_idx |

## Verification
A table of runs covers several mixes of block count, block size, request back-pressure pattern, response latency and consumer delay. A run of twenty blocks makes the address counter wrap inside the bank, and a run with `reqs` equal to MAX_REQS fills a slot completely. Continuous back-pressure patterns show whether requests are held or dropped. Long latencies together with slow consumers show whether the look-ahead order and slot reuse are kept. A directed case returns the other tag's response first, to show that a block's readiness depends only on its own tag. Further directed cases check stray responses, a zero-length run and a `start` pulse during a busy run.

// File: rtl/tagrd_pkg.sv
// Package: shared constants and types for the tagged block read engine.
// Assumes exactly two buffer slots, each slot owning one transaction tag.
package tagrd_pkg;
    localparam int NUM_TAGS = 2;
    localparam int TAG_W    = 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/tagrd_issue.sv
// Issue sequencer: walks blocks and requests in order and presents one read
// request at a time. The tag is the low bit of the block number. The address
// is a running offset inside one bank window. The first request of a block
// waits until that block's slot is free.
// Assumes: launch only while not running; 1 <= cfg_reqs.
module tagrd_issue
    import tagrd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BANK_AW  = 6,
    parameter int BANK_SEL = 5,
    parameter int BLK_W    = 8,
    parameter int REQ_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [BLK_W-1:0]    cfg_nblk,
    input  logic [REQ_W-1:0]    cfg_reqs,
    input  logic                run,
    input  logic [NUM_TAGS-1:0] slot_busy,
    input  logic                req_ready,
    output logic                req_valid,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [TAG_W-1:0]    req_tag,
    output logic                first_req,
    output logic [BLK_W-1:0]    iss_blk,
    output logic                iss_all
);
    localparam int HI_W = ADDR_W - BANK_AW;

    logic [BLK_W-1:0]   nblk_q;
    logic [REQ_W-1:0]   reqs_q;
    logic [REQ_W-1:0]   iss_req;
    logic [BANK_AW-1:0] off_q;
    logic               accept;

    // Purpose: decode the request outputs from the issue position.
    always_comb begin
        req_tag   = iss_blk[TAG_W-1:0];
        first_req = (iss_req == '0);
        req_valid = run && !iss_all && (!first_req || !slot_busy[req_tag]);
        req_addr  = {HI_W'(BANK_SEL), off_q};
        accept    = req_valid && req_ready;
    end

    // Purpose: advance the request, block and address counters on each accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nblk_q  <= '0;
            reqs_q  <= '0;
            iss_blk <= '0;
            iss_req <= '0;
            off_q   <= '0;
            iss_all <= 1'b1;
        end else if (launch) begin
            nblk_q  <= cfg_nblk;
            reqs_q  <= cfg_reqs;
            iss_blk <= '0;
            iss_req <= '0;
            off_q   <= '0;
            iss_all <= (cfg_nblk == '0);
        end else if (accept) begin
            off_q <= off_q + BANK_AW'(1);
            if (iss_req == reqs_q - REQ_W'(1)) begin
                iss_req <= '0;
                if (iss_blk == nblk_q - BLK_W'(1)) begin
                    iss_all <= 1'b1;
                end else begin
                    iss_blk <= iss_blk + BLK_W'(1);
                end
            end else begin
                iss_req <= iss_req + REQ_W'(1);
            end
        end
    end

    // R7: a stalled request stays presented and unchanged
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_tag));
endmodule

// File: rtl/tagrd_tag_ctr.sv
// Outstanding-request counter for one transaction tag. It counts up on an
// accepted request and down on a returned response with this tag.
// Assumes the caller never decrements at zero.
module tagrd_tag_ctr #(
    parameter int CNT_W = 4,
    parameter int MAX   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    // Purpose: hold the number of requests of this tag still in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R4: a tag never has more requests in flight than one block holds
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX));
endmodule

// File: rtl/tagrd_slot_buf.sv
// Two-slot block store. Response beats of a slot are written in arrival
// order through a per-slot write pointer. The pointer is cleared when a new
// block claims the slot. Reads are combinational by slot and beat index.
// Assumes a slot is never cleared and written in the same cycle.
module tagrd_slot_buf
    import tagrd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MAX_REQS = 8,
    parameter int IDX_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [TAG_W-1:0]  clr_slot,
    input  logic [TAG_W-1:0]  rd_slot,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem  [NUM_TAGS][MAX_REQS];
    logic [IDX_W-1:0]  wptr [NUM_TAGS];

    // Purpose: move each slot's write pointer on a write or a new block.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_TAGS; s++) begin
            if (!rst_n) begin
                wptr[s] <= '0;
            end else if (clr_en && clr_slot == TAG_W'(s)) begin
                wptr[s] <= '0;
            end else if (wr_en && wr_slot == TAG_W'(s)) begin
                wptr[s] <= wptr[s] + IDX_W'(1);
            end
        end
    end

    // Purpose: store a returned beat at its slot's write pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_slot][wptr[wr_slot]] <= wr_data;
        end
    end

    assign rd_data = mem[rd_slot][rd_idx];

    // R5: a slot is never reclaimed while a beat for it is being stored
    p_no_clr_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_en && wr_en && clr_slot == wr_slot));
endmodule

// File: rtl/tagrd_engine.sv
// Tagged block read engine top. It sequences the run, keeps one counter per
// tag, and waits on block k only after block k+1 has been fully issued. It
// offers finished blocks to the consumer in order and frees a slot on
// acknowledge. Stray responses raise a sticky error.
// Assumes responses of one tag return in request order.
module tagrd_engine
    import tagrd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int BANK_AW  = 6,
    parameter int BANK_SEL = 5,
    parameter int BLK_W    = 8,
    parameter int MAX_REQS = 8,
    localparam int REQ_W   = $clog2(MAX_REQS + 1),
    localparam int IDX_W   = $clog2(MAX_REQS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  cfg_nblk,
    input  logic [REQ_W-1:0]  cfg_reqs,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_tag,
    input  logic              rsp_valid,
    input  logic              rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              blk_valid,
    output logic              blk_slot,
    input  logic              blk_ack,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BLK_X = BLK_W + 1;

    phase_e            phase;
    logic [BLK_W-1:0]  nblk_q;
    logic [BLK_W-1:0]  wait_blk;
    logic [NUM_TAGS-1:0] slot_busy;
    logic              err_q;
    logic              launch, run, accept, first_req, rsp_ok, hand, next_issued;
    logic [BLK_W-1:0]  iss_blk;
    logic              iss_all;
    logic [TAG_W-1:0]  wslot;
    logic [REQ_W-1:0]  cnt [NUM_TAGS];

    tagrd_issue #(
        .ADDR_W(ADDR_W), .BANK_AW(BANK_AW), .BANK_SEL(BANK_SEL),
        .BLK_W(BLK_W), .REQ_W(REQ_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cfg_nblk(cfg_nblk),
        .cfg_reqs(cfg_reqs), .run(run), .slot_busy(slot_busy),
        .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
        .req_tag(req_tag), .first_req(first_req), .iss_blk(iss_blk),
        .iss_all(iss_all)
    );

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
        tagrd_tag_ctr #(.CNT_W(REQ_W), .MAX(MAX_REQS)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clr(launch),
            .inc(accept && req_tag == TAG_W'(t)),
            .dec(rsp_ok && rsp_tag == TAG_W'(t)),
            .cnt(cnt[t])
        );
    end

    tagrd_slot_buf #(.DATA_W(DATA_W), .MAX_REQS(MAX_REQS), .IDX_W(IDX_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rsp_ok), .wr_slot(rsp_tag), .wr_data(rsp_data),
        .clr_en(accept && first_req), .clr_slot(req_tag),
        .rd_slot(wslot), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // Purpose: decode control strobes and the per-tag wait condition.
    always_comb begin
        run         = (phase == PH_RUN);
        launch      = start && !run;
        accept      = req_valid && req_ready;
        rsp_ok      = rsp_valid && (cnt[rsp_tag] != '0);
        wslot       = wait_blk[TAG_W-1:0];
        next_issued = iss_all || ({1'b0, iss_blk} > ({1'b0, wait_blk} + BLK_X'(1)));
        blk_valid   = run && (wait_blk < nblk_q) && next_issued
                      && slot_busy[wslot] && (cnt[wslot] == '0);
        blk_slot    = wslot;
        hand        = blk_valid && blk_ack;
        busy        = run;
        done        = (phase == PH_DONE);
        err         = err_q;
    end

    // Purpose: run phase, handover pointer and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            nblk_q   <= '0;
            wait_blk <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= launch ? 1'b0 : (err_q || (rsp_valid && !rsp_ok));
            if (launch) begin
                phase    <= (cfg_nblk == '0) ? PH_DONE : PH_RUN;
                nblk_q   <= cfg_nblk;
                wait_blk <= '0;
            end else if (hand) begin
                wait_blk <= wait_blk + BLK_W'(1);
                if (wait_blk == nblk_q - BLK_W'(1)) begin
                    phase <= PH_DONE;
                end
            end
        end
    end

    // Purpose: mark a slot taken by a new block and free it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            slot_busy <= '0;
        end else begin
            for (int s = 0; s < NUM_TAGS; s++) begin
                if (accept && first_req && req_tag == TAG_W'(s)) begin
                    slot_busy[s] <= 1'b1;
                end else if (hand && wslot == TAG_W'(s)) begin
                    slot_busy[s] <= 1'b0;
                end
            end
        end
    end

    // R3: an offered block stays offered, on the same slot, until acknowledged
    p_blk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid && !blk_ack && !start |=> blk_valid && $stable(blk_slot));
    // R8: the error flag only clears on a new start
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err && !start |=> err);
    // R9: no request is presented once the run is done
    p_quiet_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid);
endmodule

// File: tb/test_tagrd_engine.sv
// Bench for tagrd_engine: a table of runs walked by one loop, followed by
// directed cases for reset, per-tag waiting, stray responses and zero length.
module test_tagrd_engine;
    localparam int CLK_PERIOD = 20;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int BANK_AW  = 6;
    localparam int BANK_SEL = 5;
    localparam int BLK_W    = 8;
    localparam int MAX_REQS = 8;
    localparam int REQ_W    = $clog2(MAX_REQS + 1);
    localparam int IDX_W    = $clog2(MAX_REQS);

    typedef struct packed {
        logic [7:0] nblk;
        logic [3:0] reqs;
        logic [1:0] rmode;
        logic [3:0] lat;
        logic [3:0] gap;
        logic       restart;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{8'd4,  4'd4, 2'd0, 4'd3, 4'd1, 1'b0},
        '{8'd5,  4'd2, 2'd1, 4'd7, 4'd2, 1'b0},
        '{8'd3,  4'd8, 2'd2, 4'd2, 4'd3, 1'b0},
        '{8'd20, 4'd4, 2'd0, 4'd1, 4'd1, 1'b0},
        '{8'd1,  4'd3, 2'd1, 4'd5, 4'd1, 1'b0},
        '{8'd3,  4'd2, 2'd0, 4'd9, 4'd4, 1'b1},
        '{8'd6,  4'd1, 2'd2, 4'd4, 4'd2, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [BLK_W-1:0] cfg_nblk = '0;
    logic [REQ_W-1:0] cfg_reqs = '0;
    logic busy, done, err, req_valid, req_tag, blk_valid, blk_slot;
    logic req_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr;
    logic rsp_valid = 1'b0;
    logic rsp_tag = 1'b0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic blk_ack = 1'b0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [DATA_W-1:0] rd_data;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tagrd_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_AW(BANK_AW),
        .BANK_SEL(BANK_SEL), .BLK_W(BLK_W), .MAX_REQS(MAX_REQS)
    ) i_tagrd_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_nblk(cfg_nblk),
        .cfg_reqs(cfg_reqs), .busy(busy), .done(done), .err(err),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_data(rsp_data), .blk_valid(blk_valid), .blk_slot(blk_slot),
        .blk_ack(blk_ack), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [DATA_W-1:0] exp_data(input int a);
        return 32'hA500_0000 ^ (32'(a) * 32'h0001_0101);
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input int a);
        return {(ADDR_W - BANK_AW)'(BANK_SEL), BANK_AW'(a)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic run_scenario(input vec_t v);
        int acc = 0;
        int ret = 0;
        int hb = 0;
        int cyc = 0;
        int eb;
        int lim;
        bit prev_stall = 1'b0;
        logic [ADDR_W-1:0] prev_addr = '0;
        int q_due [256];
        logic q_tag [256];
        logic [DATA_W-1:0] q_dat [256];
        int q_wr = 0;
        int q_rd = 0;
        @(negedge clk);
        cfg_nblk = v.nblk;
        cfg_reqs = REQ_W'(v.reqs);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 5000) begin
            // R7: a stalled request must still be there, unchanged
            if (prev_stall)
                chk(req_valid && req_addr == prev_addr, "R7", "stall hold",
                    64'(req_addr), 64'(prev_addr));
            // R1, R2, R6: check the presented request
            if (req_valid) begin
                eb = acc / int'(v.reqs);
                chk(req_tag == eb[0], "R1", "request tag", 64'(req_tag), 64'(eb[0]));
                chk(req_addr == exp_addr(acc), "R2", "request address",
                    64'(req_addr), 64'(exp_addr(acc)));
                if (acc % int'(v.reqs) == 0 && eb >= 2)
                    chk(hb >= eb - 1, "R6", "slot reuse before ack", 64'(hb), 64'(eb - 1));
            end
            // R3, R4, R5, R1: block handover
            blk_ack = 1'b0;
            if (blk_valid && (cyc % int'(v.gap) == 0)) begin
                lim = (hb + 2 < int'(v.nblk)) ? hb + 2 : int'(v.nblk);
                chk(acc >= lim * int'(v.reqs), "R3", "next block issued before wait",
                    64'(acc), 64'(lim * int'(v.reqs)));
                chk(ret >= (hb + 1) * int'(v.reqs), "R4", "all responses returned",
                    64'(ret), 64'((hb + 1) * int'(v.reqs)));
                chk(blk_slot == hb[0], "R1", "offered slot", 64'(blk_slot), 64'(hb[0]));
                for (int i = 0; i < int'(v.reqs); i++) begin
                    rd_idx = IDX_W'(i);
                    #1;
                    chk(rd_data == exp_data(hb * int'(v.reqs) + i), "R5", "block beat",
                        64'(rd_data), 64'(exp_data(hb * int'(v.reqs) + i)));
                end
                blk_ack = 1'b1;
                hb++;
            end
            // R11: poke start during the run with a different config
            if (v.restart && cyc == 3) begin
                start = 1'b1;
                cfg_nblk = 8'd1;
            end else begin
                start = 1'b0;
            end
            // response from the in-order return queue
            if (q_rd < q_wr && q_due[q_rd] <= cyc) begin
                rsp_valid = 1'b1;
                rsp_tag   = q_tag[q_rd];
                rsp_data  = q_dat[q_rd];
                q_rd++;
                ret++;
            end else begin
                rsp_valid = 1'b0;
            end
            // back-pressure pattern for the coming edge
            case (v.rmode)
                2'd1:    req_ready = (cyc % 2) == 1;
                2'd2:    req_ready = (cyc % 3) == 2;
                default: req_ready = 1'b1;
            endcase
            prev_stall = req_valid && !req_ready;
            prev_addr  = req_addr;
            if (req_valid && req_ready) begin
                q_due[q_wr] = cyc + int'(v.lat);
                q_tag[q_wr] = req_tag;
                q_dat[q_wr] = exp_data(acc);
                q_wr++;
                acc++;
            end
            @(negedge clk);
            cyc++;
        end
        blk_ack = 1'b0;
        start = 1'b0;
        rsp_valid = 1'b0;
        req_ready = 1'b0;
        chk(done == 1'b1, "R9", "run finished", 64'(done), 64'd1);
        chk(hb == int'(v.nblk), "R9", "blocks handed over", 64'(hb), 64'(v.nblk));
        chk(acc == int'(v.nblk) * int'(v.reqs), "R7", "requests accepted",
            64'(acc), 64'(int'(v.nblk) * int'(v.reqs)));
        chk(err == 1'b0, "R8", "no spurious error", 64'(err), 64'd0);
        chk(busy == 1'b0, "R9", "not busy after done", 64'(busy), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R10: outputs idle during and after reset
        repeat (3) @(negedge clk);
        chk(!req_valid && !blk_valid && !busy && !done && !err, "R10", "in reset",
            64'({req_valid, blk_valid, busy, done, err}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_valid && !blk_valid && !busy && !done && !err, "R10", "after reset",
            64'({req_valid, blk_valid, busy, done, err}), 64'd0);

        for (int n = 0; n < NVEC; n++) run_scenario(VECS[n]);

        // R4: the other tag's response must not make block 0 ready
        @(negedge clk);
        cfg_nblk = 8'd2; cfg_reqs = REQ_W'(1); start = 1'b1; req_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        req_ready = 1'b0;
        rsp_valid = 1'b1; rsp_tag = 1'b1; rsp_data = 32'h1111_0001;
        @(negedge clk);
        rsp_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(blk_valid == 1'b0, "R4", "other tag left block 0 waiting", 64'(blk_valid), 64'd0);
        chk(err == 1'b0, "R8", "owned response is no error", 64'(err), 64'd0);
        rsp_valid = 1'b1; rsp_tag = 1'b0; rsp_data = 32'h2222_0000;
        @(negedge clk);
        rsp_valid = 1'b0;
        rd_idx = '0;
        #1;
        chk(blk_valid && blk_slot == 1'b0, "R4", "block 0 ready on own tag",
            64'({blk_valid, blk_slot}), 64'b10);
        chk(rd_data == 32'h2222_0000, "R5", "block 0 beat", 64'(rd_data), 64'h2222_0000);
        blk_ack = 1'b1;
        @(negedge clk);
        blk_ack = 1'b0;
        #1;
        chk(blk_valid && blk_slot == 1'b1, "R1", "block 1 on slot 1",
            64'({blk_valid, blk_slot}), 64'b11);
        chk(rd_data == 32'h1111_0001, "R5", "block 1 beat", 64'(rd_data), 64'h1111_0001);
        blk_ack = 1'b1;
        @(negedge clk);
        blk_ack = 1'b0;
        chk(done && !busy, "R9", "done after last ack", 64'({done, busy}), 64'b10);

        // R8: stray response sets a sticky flag, cleared by start
        rsp_valid = 1'b1; rsp_tag = 1'b0; rsp_data = 32'hDEAD_BEEF;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(err == 1'b1, "R8", "stray response flagged", 64'(err), 64'd1);
        chk(blk_valid == 1'b0, "R8", "stray response not offered", 64'(blk_valid), 64'd0);
        repeat (2) @(negedge clk);
        chk(err == 1'b1, "R8", "flag sticky", 64'(err), 64'd1);

        // R9: a zero-block run finishes at once and clears the error
        cfg_nblk = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy && !req_valid, "R9", "zero-block run",
            64'({done, busy, req_valid}), 64'b100);
        chk(err == 1'b0, "R8", "start clears flag", 64'(err), 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule